// File: doc/BRIEF.md
# Burst Cache Address Sequencer

This block is the control front end of a synchronous burst cache memory. On each rising clock edge it samples an external word address, three chip selects, two burst-start strobes (one driven by the processor and one by the cache controller), an advance input and a combined write request. From these it produces the internal word address for the array, a flag marking each cycle that carries an access, a read/write indication and a deselect flag. The memory array, the data pipeline and the output drivers belong to a separate datapath block.

A burst covers four words. Only the two low address bits change during a burst. A static mode input selects the order of those bits. In linear order the offset counts up modulo four from the start offset. In interleaved order the start offset is XORed with a beat count that runs from 0 to 3. After the fourth word the sequence wraps to its start. Between strobes, the advance input either steps the burst forward or holds it on the current word. The address width is a parameter.

Top module: `burst_seq`

## Requirements
- R1: While rst_ni is low, desel_o is 1, acc_vld_o is 0, wr_o is 0 and word_addr_o is 0.
- R2: A processor start is proc_strb_ni low with cs1_ni low. When the chip is selected, it loads addr_i and starts a read burst at offset 0 in the next cycle (word_addr_o equals addr_i, acc_vld_o 1, wr_o 0). It does this whatever wr_ni and ctrl_strb_ni are on that edge.
- R3: A controller start is ctrl_strb_ni low while no processor start is present on the same edge. When the chip is selected, it loads addr_i. wr_o in the next cycle equals the inverse of wr_ni sampled on that edge.
- R4: The chip is selected only when cs1_ni is 0, cs2_i is 1 and cs2_ni is 0. A start strobe on an edge where the chip is not selected gives desel_o 1 and acc_vld_o 0 in the next cycle.
- R5: When cs1_ni is high, a low proc_strb_ni is treated as absent. The edge then behaves as a continue cycle.
- R6: adv_ni is ignored on the edge that samples a start. The first word is always the start address.
- R7: During a burst, on an edge with no start, adv_ni low moves to the next burst word. adv_ni high keeps the current word, and acc_vld_o stays 1.
- R8: With ilv_mode_i 0, the low two bits of word_addr_o at beat k are (start offset + k) mod 4.
- R9: With ilv_mode_i 1, the low two bits of word_addr_o at beat k are start offset XOR k.
- R10: After the fourth word the burst wraps to the start word. Address bits above bit 1 never change within a burst.
- R11: Within a burst, an edge with wr_ni low sets wr_o from the next cycle on. Continue cycles keep wr_o set until the next start.
- R12: While deselected, an edge with no start strobe leaves desel_o 1 and acc_vld_o 0, whatever adv_ni is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | External word address |
| proc_strb_ni | input | 1 | Processor burst-start strobe, active low |
| ctrl_strb_ni | input | 1 | Controller burst-start strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| cs1_ni | input | 1 | Chip select, active low; also gates the processor strobe |
| cs2_i | input | 1 | Chip select, active high |
| cs2_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Combined write request, active low |
| ilv_mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| word_addr_o | output | AW | Internal word address |
| acc_vld_o | output | 1 | Current cycle carries an access |
| wr_o | output | 1 | Current access is a write |
| desel_o | output | 1 | Device is deselected |

## Verification
The bench sweeps all four start offsets in both orders, for both strobe kinds, and compares every beat against the two sequences computed arithmetically. This catches a design that uses the wrong order or that carries out of bit 1 into the upper address. It drives adv_ni low on the start edge: a design that samples advance there skips the first word. It drives wr_ni low on a processor start: a design that samples it there turns a read into a write. It raises cs1_ni with the processor strobe low in the middle of a burst: a design that does not block the strobe reloads the address. It also drives each chip select inactive in turn. A wrong select decode either keeps the device enabled or fails to deselect it.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} burst_ord_e;

  function automatic logic [1:0] burst_offset(input logic [1:0] start, input logic [1:0] beat,
                                              input burst_ord_e ord);
    return (ord == ORD_INTERLEAVE) ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/burst_strobe_dec.sv
module burst_strobe_dec (
  input  logic proc_strb_ni,
  input  logic ctrl_strb_ni,
  input  logic cs1_ni,
  input  logic cs2_i,
  input  logic cs2_ni,
  output logic start_o,
  output logic ctrl_start_o,
  output logic sel_o
);
  logic proc_act;
  // processor strobe is blocked by cs1 high
  assign proc_act     = ~proc_strb_ni & ~cs1_ni;
  assign ctrl_start_o = ~ctrl_strb_ni & ~proc_act;
  assign start_o      = proc_act | ctrl_start_o;
  assign sel_o        = ~cs1_ni & cs2_i & ~cs2_ni;
endmodule

// File: rtl/burst_ctr.sv
module burst_ctr
  import burst_seq_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] base_i,
  input  logic          mode_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base_q;
  logic [1:0]    beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      beat_q <= '0;
    end else if (step_i) begin
      beat_q <= beat_q + 2'd1;
    end
  end

  assign addr_o = {base_q[AW-1:2], burst_offset(base_q[1:0], beat_q, burst_ord_e'(mode_i))};
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int AW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          proc_strb_ni,
  input  logic          ctrl_strb_ni,
  input  logic          adv_ni,
  input  logic          cs1_ni,
  input  logic          cs2_i,
  input  logic          cs2_ni,
  input  logic          wr_ni,
  input  logic          ilv_mode_i,
  output logic [AW-1:0] word_addr_o,
  output logic          acc_vld_o,
  output logic          wr_o,
  output logic          desel_o
);
  logic start, ctrl_start, sel;
  logic active_q, wr_q;

  burst_strobe_dec u_dec (
    .proc_strb_ni (proc_strb_ni),
    .ctrl_strb_ni (ctrl_strb_ni),
    .cs1_ni       (cs1_ni),
    .cs2_i        (cs2_i),
    .cs2_ni       (cs2_ni),
    .start_o      (start),
    .ctrl_start_o (ctrl_start),
    .sel_o        (sel)
  );

  burst_ctr #(.AW(AW)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start & sel),
    .step_i (~start & active_q & ~adv_ni),
    .base_i (addr_i),
    .mode_i (ilv_mode_i),
    .addr_o (word_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
    end else if (start) begin
      active_q <= sel;
      wr_q     <= sel & ctrl_start & ~wr_ni;
    end else if (active_q) begin
      wr_q <= wr_q | ~wr_ni;
    end
  end

  assign acc_vld_o = active_q;
  assign wr_o      = wr_q;
  assign desel_o   = ~active_q;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int AW = 17
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          proc_strb_ni,
  input logic          ctrl_strb_ni,
  input logic          adv_ni,
  input logic          cs1_ni,
  input logic          cs2_i,
  input logic          cs2_ni,
  input logic          wr_ni,
  input logic          ilv_mode_i,
  input logic [AW-1:0] word_addr_o,
  input logic          acc_vld_o,
  input logic          wr_o,
  input logic          desel_o
);
  logic p_go, c_go, any_go, chip_on;
  assign p_go    = !proc_strb_ni && !cs1_ni;
  assign c_go    = !ctrl_strb_ni && !p_go;
  assign any_go  = p_go || c_go;
  assign chip_on = !cs1_ni && cs2_i && !cs2_ni;

  always @(posedge clk_i)
    if (!rst_ni) AST_RESET_IDLE: assert (desel_o && !acc_vld_o && !wr_o); // R1

  AST_PROC_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_go && chip_on) |=> (acc_vld_o && !wr_o && word_addr_o == $past(addr_i))); // R2
  AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_go && chip_on) |=> (wr_o == !$past(wr_ni))); // R3
  AST_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_go && !chip_on) |=> (desel_o && !acc_vld_o)); // R4
  AST_SUSPEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_o && !any_go && adv_ni) |=>
      (word_addr_o == $past(word_addr_o) || ilv_mode_i != $past(ilv_mode_i))); // R7
  AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_o && !any_go) |=> (word_addr_o[AW-1:2] == $past(word_addr_o[AW-1:2]))); // R10
  AST_WRITE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_o && !any_go && (wr_o || !wr_ni)) |=> wr_o); // R11
  AST_STAY_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desel_o && !any_go) |=> (desel_o && !acc_vld_o)); // R12
endmodule

bind burst_seq burst_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/burst_seq_tb.sv
module burst_seq_tb;
  localparam int AW = 10;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic proc_n = 1, ctrl_n = 1, adv_n = 1, cs1_n = 0, cs2 = 1, cs2_n = 0, wr_n = 1, mode = 0;
  logic [AW-1:0] word_addr;
  logic vld, wr, desel;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  burst_seq #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .proc_strb_ni(proc_n), .ctrl_strb_ni(ctrl_n),
    .adv_ni(adv_n), .cs1_ni(cs1_n), .cs2_i(cs2), .cs2_ni(cs2_n), .wr_ni(wr_n),
    .ilv_mode_i(mode), .word_addr_o(word_addr), .acc_vld_o(vld), .wr_o(wr), .desel_o(desel)
  );

  task automatic check(input int act, input int exp, input string req);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    proc_n = 1; ctrl_n = 1; adv_n = 1; cs1_n = 0; cs2 = 1; cs2_n = 0; wr_n = 1;
  endtask

  // apply current inputs across one rising edge, return at the following falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input int k, input logic m);
    logic [1:0] lo;
    lo = m ? (b[1:0] ^ 2'(k)) : 2'(int'(b[1:0]) + k);
    return {b[AW-1:2], lo};
  endfunction

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] base;
    int beat;
    @(negedge clk);
    check(int'(desel), 1, "R1 desel"); check(int'(vld), 0, "R1 vld");
    check(int'(wr), 0, "R1 wr"); check(int'(word_addr), 0, "R1 addr");
    rst_n = 1;
    idle();
    tick();

    for (int m = 0; m < 2; m++) begin
      for (int off = 0; off < 4; off++) begin
        for (int kind = 0; kind < 2; kind++) begin
          // deselect, then change mode while idle
          ctrl_n = 0; cs2 = 0; tick();
          check(int'(desel), 1, "R4 desel cs2"); check(int'(vld), 0, "R4 vld");
          mode = m[0];
          adv_n = 0; tick();
          check(int'(desel), 1, "R12 stays deselected"); check(int'(vld), 0, "R12 vld");
          base = AW'((m * 97 + off * 13 + kind * 41) << 2) | AW'(off);
          addr = base; adv_n = 0; wr_n = 0;
          if (kind == 0) begin proc_n = 0; ctrl_n = 0; end else ctrl_n = 0;
          tick();
          addr = ~base;
          check(int'(word_addr), int'(exp_addr(base, 0, m[0])), "R6 first word ignores adv");
          check(int'(vld), 1, kind == 0 ? "R2 vld" : "R3 vld");
          check(int'(wr), kind, kind == 0 ? "R2 wr ignored" : "R3 wr sampled");
          beat = 0;
          for (int s = 0; s < 7; s++) begin
            if (s == 2) adv_n = 1;
            else if (s == 4) begin cs1_n = 1; proc_n = 0; adv_n = 1; end
            else begin adv_n = 0; beat++; end
            tick();
            check(int'(word_addr), int'(exp_addr(base, beat, m[0])),
                  m == 0 ? "R8 linear beat R10 wrap" : "R9 interleaved beat R10 wrap");
            check(int'(vld), 1, s == 4 ? "R5 blocked strobe" : "R7 vld in burst");
          end
        end
      end
    end

    // other select lines
    ctrl_n = 0; cs1_n = 1; proc_n = 1; tick();
    check(int'(desel), 1, "R4 cs1 high");
    ctrl_n = 0; cs2_n = 1; tick();
    check(int'(desel), 1, "R4 cs2_n high");

    // write becomes sticky after a read start
    addr = AW'(5); proc_n = 0; tick();
    check(int'(wr), 0, "R11 read start");
    adv_n = 0; wr_n = 0; tick();
    check(int'(wr), 1, "R11 write latched");
    adv_n = 0; wr_n = 1; tick();
    check(int'(wr), 1, "R11 write carried");
    ctrl_n = 0; wr_n = 1; tick();
    check(int'(wr), 0, "R3 controller read");

    // processor strobe wins over controller strobe; reset again
    addr = AW'(10'h2A6); proc_n = 0; ctrl_n = 0; wr_n = 0; tick();
    check(int'(word_addr), 10'h2A6, "R2 addr"); check(int'(wr), 0, "R2 wr");
    rst_n = 0; #1;
    check(int'(desel), 1, "R1 async reset"); check(int'(word_addr), 0, "R1 addr cleared");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule